// File: doc/BRIEF.md
# Masked SIMD Lane Writeback Controller

This block holds the lane control that sits around a per-lane 64-bit operation in a vector datapath up to 512 bits wide. For each issued operation it decides how many 64-bit lanes are live from a length code. It forms the second operand of each lane, either as that lane's slice of a full vector or as one 64-bit value repeated into every lane. It picks the rounding mode that the lanes use, and it writes the lane outcomes into the destination under an opmask.

A placeholder lane function stands in for the real arithmetic. It adds the two lane operands and the two-bit rounding code, and it raises a carry flag and a zero flag. This keeps the control paths observable without modelling a floating-point unit. The outcome is registered, so the destination, the merged flags and the chosen rounding mode appear one clock after an issue strobe. They hold while no operation is issued.

Top module: `lwb_ctrl`

## Requirements
- R1: The length code `vl_sel` sets the live lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes. Lane j occupies bits 64j+63 down to 64j.
- R2: `rm_used` equals `er_field` only when all three hold: the length is 512 bits (`vl_sel[1]` is 1), `bcast` is 1 and `src2_is_mem` is 0. Otherwise `rm_used` equals `glob_rm`.
- R3: When `bcast` is 1 and `src2_is_mem` is 1, every lane takes `src2[63:0]` as its second operand. In every other case lane j takes bits 64j+63:64j of `src2`.
- R4: The lane function gives the sum of the lane's `src1` slice, its second operand and `rm_used`, modulo 2^64. Its flag bit 0 is the carry out of that sum, and its flag bit 1 is set when the 64-bit sum is zero.
- R5: A live lane is written with the lane result when `no_mask` is 1 or when its `mask` bit is 1.
- R6: A live lane whose `mask` bit is 0, with `no_mask` 0 and `zeroing` 0, keeps the `old_dst` value of that lane.
- R7: A live lane whose `mask` bit is 0, with `no_mask` 0 and `zeroing` 1, is written as zero.
- R8: All destination bits from the live vector length up to bit 511 are zero.
- R9: `flags_out` is the bitwise OR of the lane flags over the lanes that are written with a result. Lanes that are kept or zeroed add nothing.
- R10: `mask` bits at or above the live lane count have no effect on any output.
- R11: `out_valid`, `dst_out`, `flags_out` and `rm_used` update one clock after a cycle with `in_valid` set. While `in_valid` is 0, `dst_out`, `flags_out` and `rm_used` hold and `out_valid` falls.
- R12: During reset, `out_valid`, `dst_out`, `flags_out` and `rm_used` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe |
| vl_sel | input | 2 | Vector length code |
| src1 | input | 512 | First operand vector |
| src2 | input | 512 | Second operand vector, or the broadcast value in the low 64 bits |
| bcast | input | 1 | Broadcast / embedded-rounding control bit |
| src2_is_mem | input | 1 | Second operand came from memory |
| er_field | input | 2 | Embedded rounding mode |
| glob_rm | input | 2 | Global rounding mode |
| old_dst | input | 512 | Prior destination contents |
| mask | input | 8 | Per-lane opmask |
| no_mask | input | 1 | Write all lanes and ignore the mask |
| zeroing | input | 1 | 1 for zeroing masking, 0 for merge masking |
| out_valid | output | 1 | Result valid |
| dst_out | output | 512 | Merged destination |
| flags_out | output | 2 | ORed flags of the written lanes |
| rm_used | output | 2 | Rounding mode applied |

## Verification
Flag gathering and mask suppression meet in one cycle when a masked-off lane would carry and a written lane next to it produces a zero result. The bench builds this on purpose with all-ones operands in the masked lane and a summing-to-zero pair in the written lane. The OR must then show only the zero flag. Zeroing and length clearing also meet when a short vector is issued with high mask bits set. A cycle-level reference model checks each such cycle on the destination, the flags and the rounding mode all at once.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  localparam int LWB_LANE_W    = 64;
  localparam int LWB_MAX_LANES = 8;
  localparam int LWB_RM_W      = 2;
  localparam int LWB_FLAG_W    = 2;

  typedef enum logic [1:0] {
    VL_SHORT = 2'b00,
    VL_MID   = 2'b01,
    VL_FULL  = 2'b10,
    VL_FULLX = 2'b11
  } vl_code_e;

  // number of live lanes for a length code
  function automatic int unsigned live_lanes(input logic [1:0] code);
    case (vl_code_e'(code))
      VL_SHORT: return 2;
      VL_MID:   return 4;
      default:  return 8;
    endcase
  endfunction

  // embedded rounding wins only for full length, control bit set, register operand
  function automatic logic take_embedded_rm(input logic [1:0] code,
                                            input logic ctl_bit,
                                            input logic from_mem);
    return code[1] && ctl_bit && !from_mem;
  endfunction

endpackage

// File: rtl/lwb_opsel.sv
module lwb_opsel #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8
) (
  input  logic [LANE_W*MAX_LANES-1:0] src2,
  input  logic                        bcast,
  input  logic                        src2_is_mem,
  output logic [LANE_W*MAX_LANES-1:0] opb
);
  logic rep_low;
  assign rep_low = bcast && src2_is_mem;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    assign opb[j*LANE_W +: LANE_W] = rep_low ? src2[LANE_W-1:0]
                                             : src2[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lwb_lane_stub.sv
module lwb_lane_stub #(
  parameter int W      = 64,
  parameter int RM_W   = 2,
  parameter int FLAG_W = 2
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [RM_W-1:0]   rm,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] flg
);
  logic [W:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{(W+1-RM_W){1'b0}}, rm};
  assign res   = total[W-1:0];
  // bit 0 carry, bit 1 zero result
  assign flg   = {(total[W-1:0] == '0), total[W]};
endmodule

// File: rtl/lwb_merge.sv
module lwb_merge
  import lwb_pkg::*;
#(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  parameter int FLAG_W    = 2
) (
  input  logic [1:0]                  vl_sel,
  input  logic [LANE_W*MAX_LANES-1:0] res_vec,
  input  logic [FLAG_W*MAX_LANES-1:0] flg_vec,
  input  logic [LANE_W*MAX_LANES-1:0] old_dst,
  input  logic [MAX_LANES-1:0]        mask,
  input  logic                        no_mask,
  input  logic                        zeroing,
  output logic [LANE_W*MAX_LANES-1:0] dst,
  output logic [FLAG_W-1:0]           flags,
  output logic [MAX_LANES-1:0]        lane_wr,
  output logic [MAX_LANES-1:0]        lane_live
);
  int unsigned lim;
  assign lim = live_lanes(vl_sel);

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    assign lane_live[j] = (j < lim);
    assign lane_wr[j]   = lane_live[j] && (no_mask || mask[j]);
    always_comb begin
      if (!lane_live[j])   dst[j*LANE_W +: LANE_W] = '0;
      else if (lane_wr[j]) dst[j*LANE_W +: LANE_W] = res_vec[j*LANE_W +: LANE_W];
      else if (zeroing)    dst[j*LANE_W +: LANE_W] = '0;
      else                 dst[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    flags = '0;
    for (int j = 0; j < MAX_LANES; j++) begin
      if (lane_wr[j]) flags = flags | flg_vec[j*FLAG_W +: FLAG_W];
    end
  end
endmodule

// File: rtl/lwb_ctrl.sv
module lwb_ctrl
  import lwb_pkg::*;
#(
  parameter int LANE_W    = LWB_LANE_W,
  parameter int MAX_LANES = LWB_MAX_LANES,
  parameter int RM_W      = LWB_RM_W,
  parameter int FLAG_W    = LWB_FLAG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [1:0]                  vl_sel,
  input  logic [LANE_W*MAX_LANES-1:0] src1,
  input  logic [LANE_W*MAX_LANES-1:0] src2,
  input  logic                        bcast,
  input  logic                        src2_is_mem,
  input  logic [RM_W-1:0]             er_field,
  input  logic [RM_W-1:0]             glob_rm,
  input  logic [LANE_W*MAX_LANES-1:0] old_dst,
  input  logic [MAX_LANES-1:0]        mask,
  input  logic                        no_mask,
  input  logic                        zeroing,
  output logic                        out_valid,
  output logic [LANE_W*MAX_LANES-1:0] dst_out,
  output logic [FLAG_W-1:0]           flags_out,
  output logic [RM_W-1:0]             rm_used
);
  localparam int VEC_W = LANE_W * MAX_LANES;

  logic [RM_W-1:0]             rm_eff;
  logic                        er_take;
  logic [VEC_W-1:0]            opb;
  logic [VEC_W-1:0]            res_vec;
  logic [FLAG_W*MAX_LANES-1:0] flg_vec;
  logic [VEC_W-1:0]            dst_nxt;
  logic [FLAG_W-1:0]           flags_nxt;
  logic [MAX_LANES-1:0]        lane_wr;
  logic [MAX_LANES-1:0]        lane_live;

  assign er_take = take_embedded_rm(vl_sel, bcast, src2_is_mem);
  assign rm_eff  = er_take ? er_field : glob_rm;

  lwb_opsel #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_opsel (
    .src2        (src2),
    .bcast       (bcast),
    .src2_is_mem (src2_is_mem),
    .opb         (opb)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_alu
    lwb_lane_stub #(.W(LANE_W), .RM_W(RM_W), .FLAG_W(FLAG_W)) u_stub (
      .a   (src1[j*LANE_W +: LANE_W]),
      .b   (opb[j*LANE_W +: LANE_W]),
      .rm  (rm_eff),
      .res (res_vec[j*LANE_W +: LANE_W]),
      .flg (flg_vec[j*FLAG_W +: FLAG_W])
    );
  end

  lwb_merge #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .FLAG_W(FLAG_W)) u_merge (
    .vl_sel    (vl_sel),
    .res_vec   (res_vec),
    .flg_vec   (flg_vec),
    .old_dst   (old_dst),
    .mask      (mask),
    .no_mask   (no_mask),
    .zeroing   (zeroing),
    .dst       (dst_nxt),
    .flags     (flags_nxt),
    .lane_wr   (lane_wr),
    .lane_live (lane_live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_out   <= '0;
      flags_out <= '0;
      rm_used   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_out   <= dst_nxt;
        flags_out <= flags_nxt;
        rm_used   <= rm_eff;
      end
    end
  end
endmodule

// File: rtl/lwb_ctrl_chk.sv
module lwb_ctrl_chk #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  parameter int RM_W      = 2,
  parameter int FLAG_W    = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [1:0]                  vl_sel,
  input logic                        bcast,
  input logic                        src2_is_mem,
  input logic [RM_W-1:0]             er_field,
  input logic [RM_W-1:0]             glob_rm,
  input logic [LANE_W*MAX_LANES-1:0] old_dst,
  input logic [MAX_LANES-1:0]        mask,
  input logic                        no_mask,
  input logic                        zeroing,
  input logic                        out_valid,
  input logic [LANE_W*MAX_LANES-1:0] dst_out,
  input logic [FLAG_W-1:0]           flags_out,
  input logic [RM_W-1:0]             rm_used,
  input logic [MAX_LANES-1:0]        lane_wr,
  input logic [MAX_LANES-1:0]        lane_live
);
  // R11
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_out) && $stable(flags_out) && $stable(rm_used)));

  // R2
  global_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !vl_sel[1]) |=> (rm_used == $past(glob_rm)));

  // R2
  embedded_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vl_sel[1] && bcast && !src2_is_mem) |=> (rm_used == $past(er_field)));

  // R6
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && !zeroing && !mask[0]) |=> (dst_out[LANE_W-1:0] == $past(old_dst[LANE_W-1:0])));

  // R7
  zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && zeroing && !mask[0]) |=> (dst_out[LANE_W-1:0] == '0));

  // R8
  short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vl_sel == 2'b00) |=> (dst_out[LANE_W*MAX_LANES-1:2*LANE_W] == '0));

  // R9
  no_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && ((mask & lane_live) == '0)) |=> (flags_out == '0));

  // R10
  upper_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr & ~lane_live) == '0);

  // R5
  nomask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_mask |-> (lane_wr == lane_live));
endmodule

bind lwb_ctrl lwb_ctrl_chk #(
  .LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .RM_W(RM_W), .FLAG_W(FLAG_W)
) u_chk (.*);

// File: tb/lwb_ctrl_test.sv
module lwb_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   vl_sel = '0;
  logic [511:0] src1 = '0, src2 = '0, old_dst = '0;
  logic         bcast = 1'b0, src2_is_mem = 1'b0;
  logic [1:0]   er_field = '0, glob_rm = '0;
  logic [7:0]   mask = '0;
  logic         no_mask = 1'b0, zeroing = 1'b0;
  logic         out_valid;
  logic [511:0] dst_out;
  logic [1:0]   flags_out, rm_used;

  logic [511:0] exp_dst = '0;
  logic [1:0]   exp_fl = '0, exp_rm = '0;
  logic         exp_v = 1'b0;
  int           checks = 0, fails = 0;
  string        tag = "R12";

  always #2 clk = ~clk;

  lwb_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vl_sel(vl_sel),
    .src1(src1), .src2(src2), .bcast(bcast), .src2_is_mem(src2_is_mem),
    .er_field(er_field), .glob_rm(glob_rm), .old_dst(old_dst), .mask(mask),
    .no_mask(no_mask), .zeroing(zeroing), .out_valid(out_valid),
    .dst_out(dst_out), .flags_out(flags_out), .rm_used(rm_used)
  );

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic compare();
    logic bad;
    bad = 1'b0;
    checks++;
    if (out_valid !== exp_v) begin
      bad = 1'b1;
      $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, exp_v);
    end
    if (dst_out !== exp_dst) begin
      bad = 1'b1;
      $display("FAIL %s dst_out actual %h expected %h", tag, dst_out, exp_dst);
    end
    if (flags_out !== exp_fl) begin
      bad = 1'b1;
      $display("FAIL %s flags_out actual %b expected %b", tag, flags_out, exp_fl);
    end
    if (rm_used !== exp_rm) begin
      bad = 1'b1;
      $display("FAIL %s rm_used actual %0d expected %0d", tag, rm_used, exp_rm);
    end
    if (bad) fails++;
  endtask

  // one cycle: check what the last issue produced, then apply new inputs
  task automatic drive(input logic v, input logic [1:0] vl, input logic [511:0] a,
                       input logic [511:0] b, input logic bc, input logic mem,
                       input logic [1:0] er, input logic [1:0] rm,
                       input logic [511:0] od, input logic [7:0] mk,
                       input logic nm, input logic zr);
    int n;
    logic [1:0] erm;
    @(negedge clk);
    compare();
    in_valid = v; vl_sel = vl; src1 = a; src2 = b; bcast = bc; src2_is_mem = mem;
    er_field = er; glob_rm = rm; old_dst = od; mask = mk; no_mask = nm; zeroing = zr;
    exp_v = v;
    if (v) begin
      n   = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
      erm = (vl[1] && bc && !mem) ? er : rm;
      exp_dst = '0;
      exp_fl  = '0;
      exp_rm  = erm;
      for (int j = 0; j < n; j++) begin
        logic [63:0] x, y;
        logic [64:0] t;
        x = a[j*64 +: 64];
        y = (bc && mem) ? b[63:0] : b[j*64 +: 64];
        t = {1'b0, x} + {1'b0, y} + {63'd0, erm};
        if (nm || mk[j]) begin
          exp_dst[j*64 +: 64] = t[63:0];
          exp_fl = exp_fl | {(t[63:0] == 64'd0), t[64]};
        end else if (!zr) begin
          exp_dst[j*64 +: 64] = od[j*64 +: 64];
        end
      end
    end
  endtask

  task automatic idle();
    drive(1'b0, 2'($urandom), rnd512(), rnd512(), 1'($urandom), 1'($urandom),
          2'($urandom), 2'($urandom), rnd512(), 8'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [511:0] ones, p, q;
    ones = '1;
    repeat (3) @(negedge clk);
    tag = "R12";
    compare();
    rst_n = 1'b1;

    // R1 R8: each length, all lanes written
    tag = "R1";
    for (int k = 0; k < 4; k++)
      drive(1, 2'(k), rnd512(), rnd512(), 0, 0, 2'd3, 2'd1, ones, 8'hFF, 1, 0);
    tag = "R8";
    drive(1, 2'b00, ones, ones, 0, 0, 2'd0, 2'd0, ones, 8'hFF, 0, 0);
    drive(1, 2'b01, ones, ones, 0, 0, 2'd0, 2'd0, ones, 8'h00, 0, 0);

    // R2 rounding choice
    tag = "R2";
    drive(1, 2'b10, rnd512(), rnd512(), 1, 0, 2'd3, 2'd1, '0, 8'hFF, 1, 0);
    drive(1, 2'b11, rnd512(), rnd512(), 1, 0, 2'd2, 2'd0, '0, 8'hFF, 1, 0);
    drive(1, 2'b01, rnd512(), rnd512(), 1, 0, 2'd3, 2'd1, '0, 8'hFF, 1, 0);
    drive(1, 2'b10, rnd512(), rnd512(), 0, 0, 2'd3, 2'd2, '0, 8'hFF, 1, 0);
    drive(1, 2'b10, rnd512(), rnd512(), 1, 1, 2'd3, 2'd1, '0, 8'hFF, 1, 0);

    // R3 broadcast from memory vs register
    tag = "R3";
    drive(1, 2'b10, rnd512(), rnd512(), 1, 1, 2'd0, 2'd0, '0, 8'hFF, 1, 0);
    drive(1, 2'b01, rnd512(), rnd512(), 1, 1, 2'd0, 2'd2, '0, 8'hFF, 1, 0);
    drive(1, 2'b10, rnd512(), rnd512(), 0, 1, 2'd0, 2'd0, '0, 8'hFF, 1, 0);

    // R4 carry and zero flags
    tag = "R4";
    p = '0; p[63:0] = 64'hFFFF_FFFF_FFFF_FFFF;
    q = '0; q[63:0] = 64'd1;
    drive(1, 2'b00, p, q, 0, 0, 2'd0, 2'd0, '0, 8'hFF, 1, 0);
    drive(1, 2'b00, p, '0, 0, 0, 2'd0, 2'd1, '0, 8'hFF, 1, 0);
    drive(1, 2'b00, '0, '0, 0, 0, 2'd0, 2'd0, '0, 8'hFF, 1, 0);

    // R5 R6 R7 masking
    tag = "R5";
    drive(1, 2'b10, rnd512(), rnd512(), 0, 0, 2'd0, 2'd1, rnd512(), 8'hA5, 0, 0);
    tag = "R6";
    drive(1, 2'b10, rnd512(), rnd512(), 0, 0, 2'd0, 2'd1, rnd512(), 8'h00, 0, 0);
    drive(1, 2'b01, rnd512(), rnd512(), 0, 0, 2'd0, 2'd3, rnd512(), 8'h06, 0, 0);
    tag = "R7";
    drive(1, 2'b10, rnd512(), rnd512(), 0, 0, 2'd0, 2'd1, rnd512(), 8'h3C, 0, 1);
    drive(1, 2'b10, rnd512(), rnd512(), 0, 0, 2'd0, 2'd1, rnd512(), 8'h00, 1, 1);

    // R9 masked lane would carry, written lane sums to zero
    tag = "R9";
    p = ones; q = ones;
    p[63:0] = '0; q[63:0] = '0;
    drive(1, 2'b00, p, q, 0, 0, 2'd0, 2'd0, '0, 8'h01, 0, 0);
    drive(1, 2'b00, p, q, 0, 0, 2'd0, 2'd0, '0, 8'h02, 0, 1);
    drive(1, 2'b00, p, q, 0, 0, 2'd0, 2'd0, '0, 8'h00, 0, 0);

    // R10 upper mask bits with a short length
    tag = "R10";
    drive(1, 2'b00, ones, ones, 0, 0, 2'd0, 2'd0, ones, 8'hFC, 0, 0);
    drive(1, 2'b01, ones, ones, 0, 0, 2'd0, 2'd0, ones, 8'hF0, 0, 1);

    // R11 idle cycles hold the last outputs
    tag = "R11";
    drive(1, 2'b10, rnd512(), rnd512(), 0, 0, 2'd0, 2'd2, rnd512(), 8'h5A, 0, 0);
    for (int k = 0; k < 5; k++) idle();

    // mixed traffic
    tag = "R5";
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 4 == 0) idle();
      else drive(1, 2'($urandom), rnd512(), rnd512(), 1'($urandom), 1'($urandom),
                 2'($urandom), 2'($urandom), rnd512(), 8'($urandom),
                 ($urandom % 5 == 0), 1'($urandom));
    end

    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule